// File: doc/BRIEF.md
# SPI NOR Flash Command Sequencer

This block turns storage requests into command frames for serial NOR flash devices that share one SPI bus. Each device has its own active-low select line. A request names an operation (read, page program or sector erase), a 24-bit address local to the device, a one-hot device mask and a byte count. The block builds the byte frames, shifts them out in SPI mode 0 with a parameterised clock divider, and moves payload bytes through a valid/ready write port (program) and a valid/ready read port (read). Each request ends with a single-cycle done pulse and a success flag.

Status polling is deferred. Each device has a write-in-progress flag. Issuing a write enable to a device sets that device's flag. The next request to the same device first runs a status frame, and only then sends its own command. No polling follows directly after a program or erase is issued. A device whose flag is clear gets its command at once. Requests that fall outside the device capacity, or that name an invalid device mask or operation, are refused without any bus activity.

Top module: `nor_cmd_seq`

## Requirements
- R1: A read (reqOp 0) sends one select frame of opcode 0x03, then the three address bytes high byte first, then reqLen dummy 0x00 bytes. The bytes clocked in during the dummy phase are returned in order on the read port.
- R2: A program (reqOp 1) first sends 0x06 alone in its own select frame and then releases select. A second frame follows: 0x02, the three address bytes high byte first, then exactly reqLen bytes taken from the write port in the order they were accepted.
- R3: An erase (reqOp 2) sends a 0x06 frame, then a frame of 0xD8 plus the three address bytes with no payload.
- R4: Sending 0x06 marks that device busy. The next accepted request for that device starts with a status frame: 0x05, then 0x00 bytes, repeated in the same frame until a returned byte has bit 0 clear. The frame then closes, the flag clears, and the request's own frames follow.
- R5: A request to a device whose busy flag is clear starts directly with its command frame. A busy flag on another device has no effect on it.
- R6: A request is refused if any of these holds: address >= CHIP_BYTES; address + length > CHIP_BYTES, where length is 65536 for erase and reqLen otherwise; reqChip not exactly one-hot; reqOp is 3. A refused request gives done with doneOk=0 and no select activity. Requests that end exactly at CHIP_BYTES are accepted.
- R7: SPI mode 0. spiSclk is low whenever no select is active. spiMosi changes only while spiSclk is low.
- R8: At most one spiCsN bit is low at any time. Between any two frames, all selects stay high for at least 2*CLK_DIV clock cycles.
- R9: doneP is high for exactly one cycle per request, with doneOk valid in that cycle. reqReady is high only while the block is idle, so it drops right after a request is accepted.
- R10: A read byte is held on rdData with rdValid until rdReady. The bus pauses while the block waits on rdReady, and while it waits on wrValid, with no loss or duplication of bytes.
- R11: After reset, all spiCsN bits are high, spiSclk is low, reqReady is high and doneP is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle and able to take a request |
| reqOp | input | 2 | 0 read, 1 program, 2 erase, 3 refused |
| reqAddr | input | 24 | Device-local byte address |
| reqChip | input | NUM_CHIPS | One-hot device mask |
| reqLen | input | LEN_W | Payload byte count (read/program) |
| wrData | input | 8 | Program payload byte |
| wrValid | input | 1 | Payload byte present |
| wrReady | output | 1 | Block takes the payload byte |
| rdData | output | 8 | Read payload byte |
| rdValid | output | 1 | Read byte present |
| rdReady | input | 1 | Consumer takes the read byte |
| doneP | output | 1 | One-cycle end-of-request pulse |
| doneOk | output | 1 | Request succeeded (valid with doneP) |
| spiSclk | output | 1 | Serial clock, idle low |
| spiMosi | output | 1 | Serial data to devices |
| spiMiso | input | 1 | Serial data from devices |
| spiCsN | output | NUM_CHIPS | Active-low device selects |

## Verification
The bench models two flash devices that decode each frame. Each device reports busy for a fixed number of status reads after a program or erase. Every request's frame bytes are compared with a queue the bench builds from the requirements. A read after a read, and a read on a different device while the first device is busy, must show no status frame. The same device after a program or erase must show a status frame of the exact expected length, which separates deferred polling from eager polling and from none at all. Address checks cover the exact capacity limit from both sides, plus bad masks and the reserved operation. Stalled rdReady and gapped wrValid patterns show that payload ordering survives backpressure.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_RSVD  = 2'd3
  } seqOp_e;

  localparam logic [7:0] CMD_WREN  = 8'h06;
  localparam logic [7:0] CMD_RDSR  = 8'h05;
  localparam logic [7:0] CMD_READ  = 8'h03;
  localparam logic [7:0] CMD_PROG  = 8'h02;
  localparam logic [7:0] CMD_ERASE = 8'hD8;
  localparam int SECTOR_BYTES = 65536;

  // Strobes from control to the shift datapath
  typedef struct packed {
    logic       shift;   // start one byte with txByte
    logic       csOn;    // drop the select of chipMask
    logic       csOff;   // raise all selects
    logic [7:0] txByte;
  } dpCtl_t;
endpackage

// File: rtl/nor_seq_dp.sv
module nor_seq_dp
  import nor_seq_pkg::*;
#(
  parameter int NUM_CHIPS = 2,
  parameter int CLK_DIV   = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtl_t               ctl,
  input  logic [NUM_CHIPS-1:0] chipMask,
  input  logic                 spiMiso,
  output logic                 spiSclk,
  output logic                 spiMosi,
  output logic [NUM_CHIPS-1:0] spiCsN,
  output logic                 byteDone,
  output logic [7:0]           rxByte
);
  localparam int DIV_W  = $clog2(CLK_DIV + 1);
  localparam int GAP    = 2 * CLK_DIV;
  localparam int GAP_W  = $clog2(GAP + 1);

  logic                 shBusy, sclkR, doneR;
  logic [DIV_W-1:0]     divCnt;
  logic [2:0]           bitCnt;
  logic [7:0]           txSh, rxSh;
  logic [NUM_CHIPS-1:0] csNR;
  logic [GAP_W-1:0]     csHighCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shBusy <= 1'b0; sclkR <= 1'b0; doneR <= 1'b0;
      divCnt <= '0; bitCnt <= '0; txSh <= '0; rxSh <= '0;
      csNR <= '1;
    end else begin
      doneR <= 1'b0;
      if (ctl.csOn)       csNR <= ~chipMask;
      else if (ctl.csOff) csNR <= '1;
      if (ctl.shift) begin
        shBusy <= 1'b1; txSh <= ctl.txByte;
        divCnt <= '0; bitCnt <= '0; sclkR <= 1'b0;
      end else if (shBusy) begin
        if (divCnt == DIV_W'(CLK_DIV - 1)) begin
          divCnt <= '0;
          if (!sclkR) begin
            sclkR <= 1'b1;
            rxSh  <= {rxSh[6:0], spiMiso};   // sample on rising edge
          end else begin
            sclkR <= 1'b0;
            if (bitCnt == 3'd7) begin
              shBusy <= 1'b0; doneR <= 1'b1;
            end else begin
              bitCnt <= bitCnt + 3'd1;
              txSh   <= {txSh[6:0], 1'b0};   // next bit on falling edge
            end
          end
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end
    end
  end

  // Cycles spent with every select high (saturating)
  always_ff @(posedge clk) begin
    if (!rstN)                csHighCnt <= GAP_W'(GAP);
    else if (!(&csNR))        csHighCnt <= '0;
    else if (csHighCnt < GAP_W'(GAP)) csHighCnt <= csHighCnt + GAP_W'(1);
  end

  assign spiSclk  = sclkR;
  assign spiMosi  = txSh[7];
  assign spiCsN   = csNR;
  assign byteDone = doneR;
  assign rxByte   = rxSh;

  // R8: never two devices selected
  a_r8_one_select: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csNR));
  // R7: clock parked low when nothing is selected
  a_r7_sclk_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    (&csNR) |-> !sclkR);
  // R7: data line only moves together with or after a falling edge
  a_r7_mosi_hold_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclkR && !ctl.shift) |=> ($stable(spiMosi) || !sclkR));
  // R8: select high for the full gap (this cycle completes it)
  a_r8_cs_gap: assert property (@(posedge clk) disable iff (!rstN)
    ctl.csOn |-> (csHighCnt >= GAP_W'(GAP - 1)));
endmodule

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
  import nor_seq_pkg::*;
#(
  parameter int NUM_CHIPS  = 2,
  parameter int CLK_DIV    = 2,
  parameter int LEN_W      = 16,
  parameter int CHIP_BYTES = 1 << 20
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [1:0]           reqOp,
  input  logic [23:0]          reqAddr,
  input  logic [NUM_CHIPS-1:0] reqChip,
  input  logic [LEN_W-1:0]     reqLen,
  input  logic [7:0]           wrData,
  input  logic                 wrValid,
  output logic                 wrReady,
  output logic                 rdValid,
  input  logic                 rdReady,
  output logic                 doneP,
  output logic                 doneOk,
  output dpCtl_t               ctl,
  output logic [NUM_CHIPS-1:0] chipMask,
  input  logic                 byteDone,
  input  logic [7:0]           rxByte
);
  localparam int GAP_CYC = 2 * CLK_DIV;
  localparam int WAIT_W  = $clog2(GAP_CYC + 1);
  localparam logic [24:0] CAP = 25'(CHIP_BYTES);

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_POLLCMD, S_POLLRD, S_WREN, S_ADDR,
    S_RDATA, S_RHOLD, S_WDATA, S_WSHIFT, S_GAP, S_DONE
  } state_e;
  typedef enum logic [1:0] {G_CMD, G_MAIN, G_DONE} gapNext_e;

  state_e               state, stateN;
  gapNext_e             gapNext, gapN;
  seqOp_e               opR;
  logic [23:0]          addrR;
  logic [NUM_CHIPS-1:0] chipR, busyFlags, busyN;
  logic [LEN_W-1:0]     remR, remN;
  logic [1:0]           idxR, idxN;
  logic [WAIT_W-1:0]    waitCnt, waitN;
  logic                 okR, okN;

  logic [24:0] span, endAddr;
  logic        reqBad;
  logic [7:0]  firstOp;
  state_e      firstState;

  always_comb begin
    span    = (opR == OP_ERASE) ? 25'(SECTOR_BYTES) : 25'(remR);
    endAddr = {1'b0, addrR} + span;
    reqBad  = ({1'b0, addrR} >= CAP) || (endAddr > CAP) ||
              !$onehot(chipR) || (opR == OP_RSVD);
    firstOp    = (opR == OP_READ) ? CMD_READ : CMD_WREN;
    firstState = (opR == OP_READ) ? S_ADDR : S_WREN;
  end

  always_comb begin
    ctl = '0;
    stateN = state; gapN = gapNext; idxN = idxR; remN = remR;
    waitN = waitCnt; busyN = busyFlags; okN = okR;
    unique case (state)
      S_IDLE: if (reqValid) begin stateN = S_CHECK; remN = reqLen; end
      S_CHECK:
        if (reqBad) begin okN = 1'b0; stateN = S_DONE; end
        else if (|(busyFlags & chipR)) begin
          ctl.csOn = 1'b1; ctl.shift = 1'b1; ctl.txByte = CMD_RDSR;
          stateN = S_POLLCMD;
        end else begin
          ctl.csOn = 1'b1; ctl.shift = 1'b1; ctl.txByte = firstOp;
          stateN = firstState; idxN = '0;
        end
      S_POLLCMD: if (byteDone) begin ctl.shift = 1'b1; stateN = S_POLLRD; end
      S_POLLRD:
        if (byteDone) begin
          if (rxByte[0]) ctl.shift = 1'b1;
          else begin
            ctl.csOff = 1'b1; busyN = busyFlags & ~chipR;
            waitN = '0; gapN = G_CMD; stateN = S_GAP;
          end
        end
      S_WREN:
        if (byteDone) begin
          ctl.csOff = 1'b1; busyN = busyFlags | chipR;
          waitN = '0; gapN = G_MAIN; stateN = S_GAP;
        end
      S_GAP:
        if (waitCnt == WAIT_W'(GAP_CYC - 1)) begin
          unique case (gapNext)
            G_CMD: begin
              ctl.csOn = 1'b1; ctl.shift = 1'b1; ctl.txByte = firstOp;
              stateN = firstState; idxN = '0;
            end
            G_MAIN: begin
              ctl.csOn = 1'b1; ctl.shift = 1'b1;
              ctl.txByte = (opR == OP_ERASE) ? CMD_ERASE : CMD_PROG;
              stateN = S_ADDR; idxN = '0;
            end
            default: begin okN = 1'b1; stateN = S_DONE; end
          endcase
        end else waitN = waitCnt + WAIT_W'(1);
      S_ADDR:
        if (byteDone) begin
          if (idxR != 2'd3) begin
            ctl.shift = 1'b1; idxN = idxR + 2'd1;
            unique case (idxR)
              2'd0:    ctl.txByte = addrR[23:16];
              2'd1:    ctl.txByte = addrR[15:8];
              default: ctl.txByte = addrR[7:0];
            endcase
          end else if (opR == OP_ERASE || remR == '0) begin
            ctl.csOff = 1'b1; waitN = '0; gapN = G_DONE; stateN = S_GAP;
          end else if (opR == OP_READ) begin
            ctl.shift = 1'b1; stateN = S_RDATA;
          end else stateN = S_WDATA;
        end
      S_RDATA: if (byteDone) stateN = S_RHOLD;
      S_RHOLD:
        if (rdReady) begin
          remN = remR - LEN_W'(1);
          if (remR == LEN_W'(1)) begin
            ctl.csOff = 1'b1; waitN = '0; gapN = G_DONE; stateN = S_GAP;
          end else begin ctl.shift = 1'b1; stateN = S_RDATA; end
        end
      S_WDATA:
        if (wrValid) begin
          ctl.shift = 1'b1; ctl.txByte = wrData; stateN = S_WSHIFT;
        end
      S_WSHIFT:
        if (byteDone) begin
          remN = remR - LEN_W'(1);
          if (remR == LEN_W'(1)) begin
            ctl.csOff = 1'b1; waitN = '0; gapN = G_DONE; stateN = S_GAP;
          end else stateN = S_WDATA;
        end
      default: stateN = S_IDLE;  // S_DONE
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; gapNext <= G_DONE; opR <= OP_READ; addrR <= '0;
      chipR <= '0; busyFlags <= '0; remR <= '0; idxR <= '0;
      waitCnt <= '0; okR <= 1'b0;
    end else begin
      state <= stateN; gapNext <= gapN; busyFlags <= busyN; remR <= remN;
      idxR <= idxN; waitCnt <= waitN; okR <= okN;
      if (state == S_IDLE && reqValid) begin
        opR <= seqOp_e'(reqOp); addrR <= reqAddr; chipR <= reqChip;
      end
    end
  end

  assign reqReady = (state == S_IDLE);
  assign wrReady  = (state == S_WDATA);
  assign rdValid  = (state == S_RHOLD);
  assign doneP    = (state == S_DONE);
  assign doneOk   = okR;
  assign chipMask = chipR;

  // R9: done is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> !doneP);
  // R9: no second request taken while one is in flight
  a_r9_accept_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
  // R6: a refused request finishes with failure and no frame
  a_r6_reject_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CHECK && reqBad) |=> (doneP && !doneOk && !ctl.csOn));
  // R4: a status frame only opens on a device marked busy
  a_r4_poll_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.csOn && ctl.txByte == CMD_RDSR) |-> |(busyFlags & chipR));
  // R4: write enable leaves the device marked busy
  a_r4_wren_marks_busy: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WREN && byteDone) |=> |(busyFlags & chipR));
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int NUM_CHIPS  = 2,
  parameter int CLK_DIV    = 2,
  parameter int LEN_W      = 16,
  parameter int CHIP_BYTES = 1 << 20
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [1:0]           reqOp,
  input  logic [23:0]          reqAddr,
  input  logic [NUM_CHIPS-1:0] reqChip,
  input  logic [LEN_W-1:0]     reqLen,
  input  logic [7:0]           wrData,
  input  logic                 wrValid,
  output logic                 wrReady,
  output logic [7:0]           rdData,
  output logic                 rdValid,
  input  logic                 rdReady,
  output logic                 doneP,
  output logic                 doneOk,
  output logic                 spiSclk,
  output logic                 spiMosi,
  input  logic                 spiMiso,
  output logic [NUM_CHIPS-1:0] spiCsN
);
  dpCtl_t               ctl;
  logic [NUM_CHIPS-1:0] chipMask;
  logic                 byteDone;
  logic [7:0]           rxByte;

  nor_seq_ctrl #(.NUM_CHIPS(NUM_CHIPS), .CLK_DIV(CLK_DIV), .LEN_W(LEN_W),
                 .CHIP_BYTES(CHIP_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqChip(reqChip), .reqLen(reqLen),
    .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady),
    .rdValid(rdValid), .rdReady(rdReady), .doneP(doneP), .doneOk(doneOk),
    .ctl(ctl), .chipMask(chipMask), .byteDone(byteDone), .rxByte(rxByte)
  );

  nor_seq_dp #(.NUM_CHIPS(NUM_CHIPS), .CLK_DIV(CLK_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .chipMask(chipMask),
    .spiMiso(spiMiso), .spiSclk(spiSclk), .spiMosi(spiMosi),
    .spiCsN(spiCsN), .byteDone(byteDone), .rxByte(rxByte)
  );

  assign rdData = rxByte;
endmodule

// File: tb/tb_nor_cmd_seq.sv
module tb_nor_cmd_seq;
  localparam int NC = 2, DIV = 2, LW = 16, CAP = 1 << 20;
  localparam int BUSY_POLLS = 3, GAP = 2 * DIV;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqReady;
  logic [1:0] reqOp = '0;
  logic [23:0] reqAddr = '0;
  logic [NC-1:0] reqChip = '0;
  logic [LW-1:0] reqLen = '0;
  logic [7:0] wrData = '0;
  logic wrValid = 1'b0, wrReady;
  logic [7:0] rdData;
  logic rdValid, rdReady = 1'b0;
  logic doneP, doneOk, spiSclk, spiMosi;
  logic misoR = 1'b0;
  logic [NC-1:0] spiCsN;

  nor_cmd_seq #(.NUM_CHIPS(NC), .CLK_DIV(DIV), .LEN_W(LW), .CHIP_BYTES(CAP)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqChip(reqChip), .reqLen(reqLen),
    .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady),
    .rdData(rdData), .rdValid(rdValid), .rdReady(rdReady),
    .doneP(doneP), .doneOk(doneOk), .spiSclk(spiSclk), .spiMosi(spiMosi),
    .spiMiso(misoR), .spiCsN(spiCsN)
  );

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- flash device model ----------------
  int  mem[int];       // key: chip<<24 | addr
  bit  erased[int];    // key: chip<<8 | sector
  int  busyCnt[NC];
  bit  wel[NC];

  function automatic int flashByte(int c, int a);
    int k = (c << 24) | (a & 24'hFFFFFF);
    if (mem.exists(k)) return mem[k];
    if (erased.exists((c << 8) | ((a >> 16) & 8'hFF))) return 8'hFF;
    return (a ^ (a >> 8) ^ (c * 16 + 8'h5A)) & 8'hFF;
  endfunction

  function automatic int statusByte(int c);
    int s = (busyCnt[c] > 0) ? 1 : 0;
    if (busyCnt[c] > 0) busyCnt[c]--;
    return s;
  endfunction

  logic [NC-1:0] prevCs = '1;
  logic prevSclk = 1'b0, prevMosi = 1'b0;
  int curChip = -1, bitCnt = 0, byteIdx = 0, frameOp = 0, frameAddr = 0;
  int highCnt = 1000;
  logic [7:0] inSh = '0, outSh = '0;
  int logQ[$];

  task automatic handleByte(input int b);
    logQ.push_back(b);
    if (byteIdx == 0) begin
      frameOp = b; frameAddr = 0;
      if (b == 5) outSh = 8'(statusByte(curChip));
    end else begin
      if (frameOp == 5) outSh = 8'(statusByte(curChip));
      else begin
        if (byteIdx <= 3) frameAddr = (frameAddr << 8) | b;
        if (frameOp == 3 && byteIdx >= 3)
          outSh = 8'(flashByte(curChip, frameAddr + byteIdx - 3));
        if (frameOp == 2 && byteIdx >= 4 && wel[curChip]) begin
          int a = (frameAddr + byteIdx - 4) & 24'hFFFFFF;
          mem[(curChip << 24) | a] = flashByte(curChip, a) & b;
        end
      end
    end
  endtask

  task automatic endFrame();
    if (frameOp == 6 && byteIdx == 1) wel[curChip] = 1;
    else if ((frameOp == 2 || frameOp == 8'hD8) && wel[curChip]) begin
      busyCnt[curChip] = BUSY_POLLS; wel[curChip] = 0;
      if (frameOp == 8'hD8 && byteIdx == 4) begin
        int keys[$];
        int sk = (curChip << 8) | ((frameAddr >> 16) & 8'hFF);
        erased[sk] = 1;
        foreach (mem[k]) if ((k >> 16) == sk) keys.push_back(k);
        foreach (keys[i]) mem.delete(keys[i]);
      end
    end
  endtask

  // Bus monitor / device model, evaluated every clock away from the edge
  always @(negedge clk) begin
    if (rstN) begin
      chk($onehot0(~spiCsN), "R8", "single select", ~spiCsN, 0);
      if (&spiCsN) chk(!spiSclk, "R7", "sclk idle low", spiSclk, 0);
      if (!(&spiCsN) && !(&prevCs) && spiMosi != prevMosi)
        chk(!spiSclk, "R7", "mosi moved with sclk high", spiSclk, 0);
      if ((&prevCs) && !(&spiCsN)) begin
        chk(highCnt >= GAP, "R8", "select gap", highCnt, GAP);
        curChip = spiCsN[0] ? 1 : 0;
        bitCnt = 0; byteIdx = 0;
        logQ.push_back(1000 + curChip);
      end
      if (curChip >= 0 && !(&spiCsN)) begin
        if (spiSclk && !prevSclk) begin
          inSh = {inSh[6:0], spiMosi};
          bitCnt++;
          if (bitCnt == 8) begin
            bitCnt = 0; handleByte(int'(inSh)); byteIdx++;
          end
        end
        if (!spiSclk && prevSclk) begin
          misoR <= outSh[7]; outSh = {outSh[6:0], 1'b0};
        end
      end
      if (curChip >= 0 && (&spiCsN)) begin endFrame(); curChip = -1; end
      highCnt = (&spiCsN) ? highCnt + 1 : 0;
    end
    prevCs = spiCsN; prevSclk = spiSclk; prevMosi = spiMosi;
  end

  // ---------------- payload ports ----------------
  int wrQ[$]; int wrStall = 0, wrCnt = 0; bit wrTake = 0;
  int rdGot[$]; int rdStall = 0, rdCnt = 0;

  always @(negedge clk) begin
    if (wrTake) void'(wrQ.pop_front());
    wrCnt++;
    wrValid = (wrQ.size() > 0) && (wrStall == 0 || (wrCnt % wrStall) == 0);
    wrData  = (wrQ.size() > 0) ? 8'(wrQ[0]) : 8'h00;
    wrTake  = wrValid && wrReady;
    rdCnt++;
    rdReady = (rdStall == 0) || ((rdCnt % rdStall) == 0);
    if (rdValid && rdReady) rdGot.push_back(int'(rdData));
  end

  // ---------------- expected frames ----------------
  int expQ[$]; int expRd[$];
  bit expBusy[NC]; int expPolls[NC];

  task automatic runReq(input int op, input int mask, input int addr, input int len,
                        input bit expOk, input string req);
    int n = 0;
    int c = (mask == 2) ? 1 : 0;
    expQ.delete(); logQ.delete(); rdGot.delete(); expRd.delete();
    if (expOk) begin
      if (expBusy[c]) begin   // R4 deferred status frame
        expQ.push_back(1000 + c); expQ.push_back(5);
        for (int i = 0; i <= expPolls[c]; i++) expQ.push_back(0);
        expBusy[c] = 0; expPolls[c] = 0;
      end
      if (op == 0) begin
        expQ.push_back(1000 + c); expQ.push_back(3);
      end else begin
        expQ.push_back(1000 + c); expQ.push_back(6);
        expQ.push_back(1000 + c); expQ.push_back(op == 1 ? 2 : 8'hD8);
        expBusy[c] = 1; expPolls[c] = BUSY_POLLS;
      end
      expQ.push_back((addr >> 16) & 8'hFF);
      expQ.push_back((addr >> 8) & 8'hFF);
      expQ.push_back(addr & 8'hFF);
      if (op == 0)
        for (int i = 0; i < len; i++) begin
          expQ.push_back(0); expRd.push_back(flashByte(c, addr + i));
        end
      if (op == 1) foreach (wrQ[i]) expQ.push_back(wrQ[i]);
    end
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'(op); reqChip = NC'(mask);
    reqAddr = 24'(addr); reqLen = LW'(len);
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk(!reqReady, "R9", {req, " ready after accept"}, reqReady, 0);
    while (!doneP && n < 20000) begin @(negedge clk); n++; end
    chk(doneP, "R9", {req, " done seen"}, doneP, 1);
    chk(doneOk == expOk, expOk ? "R9" : "R6", {req, " doneOk"}, doneOk, expOk);
    @(negedge clk);
    chk(!doneP, "R9", {req, " done single cycle"}, doneP, 0);
    chk(logQ.size() == expQ.size(), req, "frame byte count", logQ.size(), expQ.size());
    for (int i = 0; i < expQ.size() && i < logQ.size(); i++)
      if (logQ[i] != expQ[i]) begin
        chk(0, req, $sformatf("frame item %0d", i), logQ[i], expQ[i]);
        break;
      end
    chk(rdGot.size() == expRd.size(), req, "read byte count", rdGot.size(), expRd.size());
    for (int i = 0; i < expRd.size() && i < rdGot.size(); i++)
      chk(rdGot[i] == expRd[i], req, $sformatf("read byte %0d", i), rdGot[i], expRd[i]);
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(&spiCsN, "R11", "selects high", spiCsN, '1);
    chk(!spiSclk, "R11", "sclk low", spiSclk, 0);
    chk(reqReady, "R11", "ready high", reqReady, 1);
    chk(!doneP, "R11", "done low", doneP, 0);

    runReq(0, 1, 24'h000100, 4, 1, "R1 read chip0");
    wrQ = '{8'hA5, 8'h3C};
    runReq(1, 1, 24'h000102, 2, 1, "R2 program chip0");
    runReq(0, 2, 24'h000010, 2, 1, "R5 read chip1 other busy");
    rdStall = 3;
    runReq(0, 1, 24'h000100, 6, 1, "R4 R10 poll then read chip0");
    rdStall = 0;
    runReq(0, 1, 24'h000100, 1, 1, "R5 read chip0 no poll");
    runReq(2, 2, 24'h020000, 0, 1, "R3 erase chip1");
    wrQ = '{8'h12, 8'h34, 8'h56}; wrStall = 2;
    runReq(1, 2, 24'h020004, 3, 1, "R4 R10 poll then program chip1");
    wrStall = 0;
    chk(wrQ.size() == 0, "R10", "all write bytes taken", wrQ.size(), 0);
    runReq(0, 2, 24'h020003, 3, 1, "R4 read erased chip1");
    chk(rdGot.size() == 3 && rdGot[0] == 8'hFF, "R3", "erased byte", rdGot[0], 8'hFF);
    chk(rdGot.size() == 3 && rdGot[1] == 8'h12 && rdGot[2] == 8'h34, "R2",
        "programmed bytes", {rdGot[1], rdGot[2]}, 16'h1234);
    runReq(0, 1, CAP, 1, 0, "R6 start at capacity");
    runReq(0, 1, CAP - 2, 3, 0, "R6 end past capacity");
    runReq(0, 1, CAP - 2, 2, 1, "R6 end at capacity");
    runReq(2, 1, CAP - 24'h00FFFF, 0, 0, "R6 erase past capacity");
    runReq(0, 3, 24'h000000, 1, 0, "R6 two chips");
    runReq(0, 0, 24'h000000, 1, 0, "R6 no chip");
    runReq(3, 1, 24'h000000, 1, 0, "R6 reserved op");
    runReq(2, 1, CAP - 24'h010000, 0, 1, "R3 erase last sector");
    runReq(0, 1, CAP - 1, 1, 1, "R4 R3 read after last-sector erase");
    chk(rdGot.size() == 1 && rdGot[0] == 8'hFF, "R3", "last sector erased", rdGot[0], 8'hFF);

    repeat (10) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule